// File: doc/BRIEF.md
# Interrupt Source Pending/Queued State Bank

This block holds the two-bit trigger state of a small bank of interrupt sources. Each source keeps a P bit, set while an interrupt is pending or in flight, and a Q bit, set when a further trigger arrives while P is already set. Software controls a source through one load/store page per source. Loads at special offsets have a side effect: they swap in a new state and return the state that was there before. Stores can end service of the interrupt or fire the source. A separate trigger page fires the source on any write.

When a trigger finds the source idle, the block moves it to pending and pulses a notification line for that source toward the event router. Every source starts masked. A parameter selects an errata mode, in which each side-effect offset is expected in folded form. A mask parameter makes some sources level-sensitive. A level-sensitive source fires from an input pin and is re-evaluated when its interrupt is ended.

State encoding: bit 1 is P and bit 0 is Q. The states are IDLE (00), OFF (01), PEND (10) and PEND_Q (11). The transitions are:
- FIRE: IDLE to PEND on a trigger, with a notification pulse.
- LATCH: PEND to PEND_Q on a trigger.
- HOLD: OFF and PEND_Q keep their state on a trigger.
- FORCE: any state to the state chosen by a set load.
- CLEAR: any state to IDLE on an end-of-interrupt.
- REPLAY: PEND_Q to PEND with a notification on a store end-of-interrupt.
- LEVEL_FIRE: IDLE to PEND with a notification when a level-sensitive input is high.

Top module: `pq_source_bank`

## Requirements
- R1: After reset every source is in OFF (01), rsp_valid is 0 and no notify bit is set.
- R2: A load at offset 0x0C00, 0x0D00, 0x0E00 or 0x0F00 sets the addressed source to 00, 01, 10 or 11 respectively. It returns the prior state on rsp_data, with rsp_valid high in the cycle after the access.
- R3: A load at offset 0x0800 returns the current state and leaves it unchanged.
- R4: A write on the trigger page (acc_trig=1) to a source in IDLE moves it to PEND and raises that source's notify bit for exactly one cycle, the cycle after the access.
- R5: A trigger on OFF leaves OFF, on PEND gives PEND_Q, and on PEND_Q leaves PEND_Q, with no notify pulse in any of these cases.
- R6: A load at offset 0x0000 (end-of-interrupt load) clears the state to IDLE and returns {0, old Q}. On an edge source it raises no notification.
- R7: A store at offset 0x0400 (store end-of-interrupt) gives no response. If the old Q was 1 it moves the source to PEND with a notify pulse; otherwise it moves the source to IDLE.
- R8: With FOLD_EN=1 every side-effect offset o is recognised only as (o | o<<4) truncated to 16 bits. An unfolded offset that differs from its folded form is treated as unknown.
- R9: A load at an unknown offset, or a load on the trigger page, returns 00 with rsp_valid high and changes no state. A store to an unknown offset is ignored.
- R10: A level-sensitive source in IDLE with its lvl_in high moves to PEND with one notify pulse, in the cycle after the input is seen. While P is set the input never sets Q.
- R11: An end-of-interrupt on a level-sensitive source whose input is still high moves it straight to PEND, with the notify pulse in the same cycle as the response.
- R12: An access to one source never changes the state of another source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_write | input | 1 | 1 for store, 0 for load |
| acc_trig | input | 1 | 1 selects the trigger page |
| acc_src | input | SRC_W | Source index addressed |
| acc_offset | input | OFS_W | Offset within the source page |
| lvl_in | input | N_SRC | Level inputs (used by level-sensitive sources only) |
| rsp_valid | output | 1 | Load response valid |
| rsp_data | output | 2 | Load response value |
| notify | output | N_SRC | One-cycle notification pulse per source |

## Verification
Every response and every state change is registered once. A load's value and any notify pulse caused by an access are therefore due in the cycle after the clock edge that samples the access. A level input raised between edges shows its notify pulse after the next edge. The bench drives stimulus on the falling edge and samples one nanosecond after the following rising edge. The cycle after that is also sampled wherever a single-pulse property is checked. The state is read back through the plain read offset, so that every transition is checked at the ports.

// File: rtl/pq_pkg.sv
package pq_pkg;

    typedef enum logic [1:0] {
        PQ_IDLE   = 2'b00,
        PQ_OFF    = 2'b01,
        PQ_PEND   = 2'b10,
        PQ_PEND_Q = 2'b11
    } pq_e;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_READ,
        OP_EOI_LD,
        OP_SET00,
        OP_SET01,
        OP_SET10,
        OP_SET11,
        OP_EOI_ST,
        OP_TRIG
    } op_e;

    // Unfolded offsets of the side-effect accesses
    localparam logic [15:0] OFS_EOI_LD = 16'h0000;
    localparam logic [15:0] OFS_EOI_ST = 16'h0400;
    localparam logic [15:0] OFS_READ   = 16'h0800;
    localparam logic [15:0] OFS_SET00  = 16'h0C00;
    localparam logic [15:0] OFS_SET01  = 16'h0D00;
    localparam logic [15:0] OFS_SET10  = 16'h0E00;
    localparam logic [15:0] OFS_SET11  = 16'h0F00;

    // Errata form of an offset: OR with itself moved up one nibble
    function automatic logic [15:0] fold_ofs(input logic [15:0] o);
        return o | (o << 4);
    endfunction

endpackage

// File: rtl/pq_offset_decode.sv
module pq_offset_decode
    import pq_pkg::*;
#(
    parameter int OFS_W   = 16,
    parameter bit FOLD_EN = 1'b0
) (
    input  logic             acc_valid,
    input  logic             acc_write,
    input  logic             acc_trig,
    input  logic [OFS_W-1:0] acc_offset,
    output op_e              op
);

    localparam logic [15:0] K_EOI_LD = FOLD_EN ? fold_ofs(OFS_EOI_LD) : OFS_EOI_LD;
    localparam logic [15:0] K_EOI_ST = FOLD_EN ? fold_ofs(OFS_EOI_ST) : OFS_EOI_ST;
    localparam logic [15:0] K_READ   = FOLD_EN ? fold_ofs(OFS_READ)   : OFS_READ;
    localparam logic [15:0] K_SET00  = FOLD_EN ? fold_ofs(OFS_SET00)  : OFS_SET00;
    localparam logic [15:0] K_SET01  = FOLD_EN ? fold_ofs(OFS_SET01)  : OFS_SET01;
    localparam logic [15:0] K_SET10  = FOLD_EN ? fold_ofs(OFS_SET10)  : OFS_SET10;
    localparam logic [15:0] K_SET11  = FOLD_EN ? fold_ofs(OFS_SET11)  : OFS_SET11;

    always_comb begin
        op = OP_NONE;
        if (acc_valid) begin
            if (acc_trig) begin
                // Any store to the trigger page fires; loads there do nothing
                if (acc_write) op = OP_TRIG;
            end else if (acc_write) begin
                if (acc_offset == OFS_W'(K_EOI_ST)) op = OP_EOI_ST;
            end else begin
                if      (acc_offset == OFS_W'(K_EOI_LD)) op = OP_EOI_LD;
                else if (acc_offset == OFS_W'(K_READ))   op = OP_READ;
                else if (acc_offset == OFS_W'(K_SET00))  op = OP_SET00;
                else if (acc_offset == OFS_W'(K_SET01))  op = OP_SET01;
                else if (acc_offset == OFS_W'(K_SET10))  op = OP_SET10;
                else if (acc_offset == OFS_W'(K_SET11))  op = OP_SET11;
            end
        end
    end

endmodule

// File: rtl/pq_source_cell.sv
module pq_source_cell
    import pq_pkg::*;
#(
    parameter bit LEVEL = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel,
    input  op_e        op,
    input  logic       lvl_in,
    output logic [1:0] pq_o,
    output logic       notify
);

    pq_e  pq_q;
    pq_e  pq_d;
    logic fire;

    // Next-state logic: access effect first, then level re-evaluation
    always_comb begin
        pq_d = pq_q;
        fire = 1'b0;
        if (sel) begin
            unique case (op)
                OP_SET00:  pq_d = PQ_IDLE;
                OP_SET01:  pq_d = PQ_OFF;
                OP_SET10:  pq_d = PQ_PEND;
                OP_SET11:  pq_d = PQ_PEND_Q;
                OP_EOI_LD: pq_d = PQ_IDLE;
                OP_EOI_ST: begin
                    if (pq_q[0]) begin
                        pq_d = PQ_PEND;      // REPLAY of a coalesced trigger
                        fire = 1'b1;
                    end else begin
                        pq_d = PQ_IDLE;
                    end
                end
                OP_TRIG: begin
                    unique case (pq_q)
                        PQ_IDLE: begin
                            pq_d = PQ_PEND;  // FIRE
                            fire = 1'b1;
                        end
                        PQ_OFF:    pq_d = PQ_OFF;
                        PQ_PEND:   pq_d = PQ_PEND_Q;
                        PQ_PEND_Q: pq_d = PQ_PEND_Q;
                        default:   pq_d = pq_q;
                    endcase
                end
                default: pq_d = pq_q;
            endcase
        end
        if (LEVEL && lvl_in && (pq_d == PQ_IDLE)) begin
            pq_d = PQ_PEND;                  // LEVEL_FIRE
            fire = 1'b1;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) pq_q <= PQ_OFF;
        else        pq_q <= pq_d;
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) notify <= 1'b0;
        else        notify <= fire;
    end

    assign pq_o = pq_q;

endmodule

// File: rtl/pq_rsp_reg.sv
module pq_rsp_reg
    import pq_pkg::*;
#(
    parameter int N_SRC = 4,
    parameter int SRC_W = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  is_load,
    input  op_e                   op,
    input  logic [SRC_W-1:0]      src,
    input  logic [N_SRC-1:0][1:0] pq_all,
    output logic                  rsp_valid,
    output logic [1:0]            rsp_data
);

    logic [1:0] cur;
    logic [1:0] val;

    assign cur = pq_all[src];

    always_comb begin
        unique case (op)
            OP_READ, OP_SET00, OP_SET01, OP_SET10, OP_SET11: val = cur;
            OP_EOI_LD: val = {1'b0, cur[0]};
            default:   val = 2'b00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= 2'b00;
        end else begin
            rsp_valid <= is_load;
            rsp_data  <= is_load ? val : 2'b00;
        end
    end

endmodule

// File: rtl/pq_source_bank.sv
module pq_source_bank
    import pq_pkg::*;
#(
    parameter int               N_SRC      = 4,
    parameter int               OFS_W      = 16,
    parameter bit               FOLD_EN    = 1'b0,
    parameter logic [N_SRC-1:0] LEVEL_MASK = N_SRC'(1) << (N_SRC - 1),
    localparam int              SRC_W      = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic             acc_write,
    input  logic             acc_trig,
    input  logic [SRC_W-1:0] acc_src,
    input  logic [OFS_W-1:0] acc_offset,
    input  logic [N_SRC-1:0] lvl_in,
    output logic             rsp_valid,
    output logic [1:0]       rsp_data,
    output logic [N_SRC-1:0] notify
);

    op_e                   op;
    logic [N_SRC-1:0]      src_sel;
    logic [N_SRC-1:0][1:0] pq_all;

    pq_offset_decode #(
        .OFS_W   (OFS_W),
        .FOLD_EN (FOLD_EN)
    ) u_dec (
        .acc_valid  (acc_valid),
        .acc_write  (acc_write),
        .acc_trig   (acc_trig),
        .acc_offset (acc_offset),
        .op         (op)
    );

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        assign src_sel[i] = acc_valid && (acc_src == SRC_W'(i));

        pq_source_cell #(
            .LEVEL (LEVEL_MASK[i])
        ) u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .sel    (src_sel[i]),
            .op     (op),
            .lvl_in (lvl_in[i]),
            .pq_o   (pq_all[i]),
            .notify (notify[i])
        );
    end

    pq_rsp_reg #(
        .N_SRC (N_SRC),
        .SRC_W (SRC_W)
    ) u_rsp (
        .clk       (clk),
        .rst_n     (rst_n),
        .is_load   (acc_valid && !acc_write),
        .op        (op),
        .src       (acc_src),
        .pq_all    (pq_all),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );

endmodule

// File: rtl/pq_source_bank_chk.sv
module pq_source_bank_chk #(
    parameter int               N_SRC      = 4,
    parameter logic [N_SRC-1:0] LEVEL_MASK = '0
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  acc_valid,
    input logic                  acc_write,
    input logic [N_SRC-1:0]      src_sel,
    input logic [N_SRC-1:0][1:0] pq_all,
    input logic [N_SRC-1:0]      notify,
    input logic                  rsp_valid
);

    // R2: every load gets a response in the next cycle
    a_r2_load_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write) |=> rsp_valid);

    // R7: no response without a load
    a_r7_store_no_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && !acc_write) |=> !rsp_valid);

    for (genvar i = 0; i < N_SRC; i++) begin : g_chk
        // R4: a notification always leaves its source pending without Q
        a_r4_notify_pend: assert property (@(posedge clk) disable iff (!rst_n)
            notify[i] |-> (pq_all[i] == 2'b10));

        // R5: a source with P set raises nothing unless it is accessed
        a_r5_busy_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            (pq_all[i][1] && !src_sel[i]) |=> !notify[i]);

        if (LEVEL_MASK[i]) begin : g_lvl
            // R10: a level input never latches Q
            a_r10_no_q_latch: assert property (@(posedge clk) disable iff (!rst_n)
                ((pq_all[i] == 2'b10) && !src_sel[i]) |=> (pq_all[i] == 2'b10));
        end else begin : g_edge
            // R12: an edge source only moves when addressed
            a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
                !src_sel[i] |=> $stable(pq_all[i]));
        end
    end

endmodule

bind pq_source_bank pq_source_bank_chk #(
    .N_SRC      (N_SRC),
    .LEVEL_MASK (LEVEL_MASK)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .src_sel   (src_sel),
    .pq_all    (pq_all),
    .notify    (notify),
    .rsp_valid (rsp_valid)
);

// File: tb/tb_pq_source_bank.sv
module tb_pq_source_bank;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n;
    logic        acc_valid, acc_write, acc_trig;
    logic [1:0]  acc_src;
    logic [15:0] acc_offset;
    logic [3:0]  lvl_in;
    logic        rsp_valid, f_rsp_valid;
    logic [1:0]  rsp_data, f_rsp_data;
    logic [3:0]  notify, f_notify;

    pq_source_bank #(.N_SRC(4), .OFS_W(16), .FOLD_EN(1'b0), .LEVEL_MASK(4'b1000)) dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_trig(acc_trig), .acc_src(acc_src), .acc_offset(acc_offset),
        .lvl_in(lvl_in), .rsp_valid(rsp_valid), .rsp_data(rsp_data), .notify(notify));

    pq_source_bank #(.N_SRC(4), .OFS_W(16), .FOLD_EN(1'b1), .LEVEL_MASK(4'b1000)) dut_fold (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_trig(acc_trig), .acc_src(acc_src), .acc_offset(acc_offset),
        .lvl_in(lvl_in), .rsp_valid(f_rsp_valid), .rsp_data(f_rsp_data), .notify(f_notify));

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic       g_rv, gf_rv;
    logic [1:0] g_rd, gf_rd;
    logic [3:0] g_nt, gf_nt;

    localparam logic [15:0] O_EOI_LD = 16'h0000;
    localparam logic [15:0] O_EOI_ST = 16'h0400;
    localparam logic [15:0] O_READ   = 16'h0800;

    function automatic logic [15:0] o_set(input int v);
        return 16'h0C00 + 16'(v) * 16'h0100;
    endfunction

    function automatic logic [15:0] fold(input logic [15:0] o);
        return o | (o << 4);
    endfunction

    function automatic int trig_next(input int v);
        case (v)
            0: return 2;
            1: return 1;
            default: return 3;
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic acc(input logic wr, input logic trg, input int src, input logic [15:0] ofs);
        @(negedge clk);
        acc_valid  = 1'b1;
        acc_write  = wr;
        acc_trig   = trg;
        acc_src    = 2'(src);
        acc_offset = ofs;
        @(posedge clk);
        #1;
        g_rv  = rsp_valid;   g_rd  = rsp_data;   g_nt  = notify;
        gf_rv = f_rsp_valid; gf_rd = f_rsp_data; gf_nt = f_notify;
        acc_valid = 1'b0;
    endtask

    task automatic rd(input int src, output int val);
        acc(1'b0, 1'b0, src, O_READ);
        val = int'(g_rd);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int v;
        rst_n = 1'b0; acc_valid = 1'b0; acc_write = 1'b0; acc_trig = 1'b0;
        acc_src = '0; acc_offset = '0; lvl_in = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1;

        // R1: reset state
        chk("R1 rsp_valid", int'(rsp_valid), 0);
        chk("R1 notify", int'(notify), 0);
        for (int s = 0; s < 4; s++) begin
            rd(s, v);
            chk("R1 state", v, 1);
            acc(1'b0, 1'b0, s, fold(O_READ));
            chk("R1 fold state", int'(gf_rd), 1);
        end

        // R2 R3 R4 R5: sweep over edge sources, prior and forced states
        for (int s = 0; s < 3; s++) begin
            for (int pv = 0; pv < 4; pv++) begin
                for (int w = 0; w < 4; w++) begin
                    acc(1'b0, 1'b0, s, o_set(pv));
                    acc(1'b0, 1'b0, s, o_set(w));
                    chk("R2 rsp_valid", int'(g_rv), 1);
                    chk("R2 prior", int'(g_rd), pv);
                    rd(s, v);
                    chk("R3 read", v, w);
                    rd(s, v);
                    chk("R3 read again", v, w);
                    acc(1'b1, 1'b1, s, 16'h0000);
                    chk("R4 trigger no rsp", int'(g_rv), 0);
                    if (w == 0) chk("R4 notify", int'(g_nt), 1 << s);
                    else        chk("R5 no notify", int'(g_nt), 0);
                    @(posedge clk); #1;
                    chk("R4 single pulse", int'(notify), 0);
                    rd(s, v);
                    if (w == 0) chk("R4 state", v, trig_next(w));
                    else        chk("R5 state", v, trig_next(w));
                end
            end
        end

        // R12: isolation between sources
        for (int s = 0; s < 3; s++) begin
            for (int j = 0; j < 3; j++) acc(1'b0, 1'b0, j, o_set((j + 1) % 4));
            acc(1'b0, 1'b0, s, o_set(0));
            acc(1'b1, 1'b1, s, 16'h0000);
            acc(1'b1, 1'b0, s, O_EOI_ST);
            for (int j = 0; j < 3; j++) begin
                if (j != s) begin
                    rd(j, v);
                    chk("R12 other source", v, (j + 1) % 4);
                end
            end
        end

        // R6: end-of-interrupt load
        for (int w = 0; w < 4; w++) begin
            acc(1'b0, 1'b0, 1, o_set(w));
            acc(1'b0, 1'b0, 1, O_EOI_LD);
            chk("R6 rsp_valid", int'(g_rv), 1);
            chk("R6 old Q", int'(g_rd), w & 1);
            chk("R6 no notify", int'(g_nt), 0);
            rd(1, v);
            chk("R6 state", v, 0);
        end

        // R7: store end-of-interrupt, including set-11-then-EOI retrigger
        for (int w = 0; w < 4; w++) begin
            acc(1'b0, 1'b0, 1, o_set(w));
            acc(1'b1, 1'b0, 1, O_EOI_ST);
            chk("R7 no rsp", int'(g_rv), 0);
            chk("R7 notify", int'(g_nt), (w & 1) << 1);
            rd(1, v);
            chk("R7 state", v, (w & 1) ? 2 : 0);
        end

        // R9: unknown offsets and trigger-page loads
        acc(1'b0, 1'b0, 2, o_set(2));
        acc(1'b0, 1'b0, 2, 16'h0123);
        chk("R9 unknown rsp_valid", int'(g_rv), 1);
        chk("R9 unknown data", int'(g_rd), 0);
        rd(2, v);
        chk("R9 unknown load state", v, 2);
        acc(1'b1, 1'b0, 2, o_set(0));
        chk("R9 unknown store rsp", int'(g_rv), 0);
        rd(2, v);
        chk("R9 unknown store state", v, 2);
        acc(1'b0, 1'b1, 2, 16'h0000);
        chk("R9 trig page load data", int'(g_rd), 0);
        chk("R9 trig page load notify", int'(g_nt), 0);
        rd(2, v);
        chk("R9 trig page load state", v, 2);

        // R8: folded offsets in the errata instance
        for (int w = 0; w < 4; w++) begin
            acc(1'b0, 1'b0, 0, fold(o_set(w)));
            acc(1'b0, 1'b0, 0, fold(O_READ));
            chk("R8 fold set/read", int'(gf_rd), w);
            acc(1'b0, 1'b0, 0, o_set(3 - w));
            chk("R8 unfolded set data", int'(gf_rd), 0);
            acc(1'b0, 1'b0, 0, O_READ);
            chk("R8 unfolded read data", int'(gf_rd), 0);
            acc(1'b0, 1'b0, 0, fold(O_READ));
            chk("R8 state kept", int'(gf_rd), w);
        end
        acc(1'b1, 1'b0, 0, fold(O_EOI_ST));
        chk("R8 fold store EOI notify", int'(gf_nt), 1);
        acc(1'b0, 1'b0, 0, O_EOI_LD);
        chk("R8 EOI load old Q", int'(gf_rd), 0);
        acc(1'b0, 1'b0, 0, fold(O_READ));
        chk("R8 EOI load state", int'(gf_rd), 0);

        // R10 R11: level-sensitive source 3
        acc(1'b0, 1'b0, 3, o_set(0));
        rd(3, v);
        chk("R10 idle low", v, 0);
        @(negedge clk) lvl_in = 4'b1000;
        @(posedge clk); #1;
        chk("R10 level notify", int'(notify), 8);
        @(posedge clk); #1;
        chk("R10 single pulse", int'(notify), 0);
        repeat (3) @(posedge clk);
        rd(3, v);
        chk("R10 no Q latched", v, 2);
        acc(1'b0, 1'b0, 3, O_EOI_LD);
        chk("R11 EOI data", int'(g_rd), 0);
        chk("R11 immediate refire", int'(g_nt), 8);
        rd(3, v);
        chk("R11 state", v, 2);
        @(negedge clk) lvl_in = 4'b0000;
        acc(1'b0, 1'b0, 3, O_EOI_LD);
        chk("R11 low no refire", int'(g_nt), 0);
        rd(3, v);
        chk("R11 low state", v, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule